// File: doc/BRIEF.md
# Dual-Enable Synchronous Loadable Binary Counter

This block is a synchronous binary up counter whose every action takes effect on the rising clock edge. It has an active-low clear and an active-low parallel load with a data word, and two count enables. Both enables must be high for the count to advance. Only the second enable, called the cascade enable, also qualifies the terminal-count carry. Several counters can therefore be chained into a wider one by feeding each stage's carry into the next stage's cascade enable, while one shared enable starts or stops the whole chain.

A build-time option makes the counter cycle over a reduced range. When the option is set and the counter is counting at the configured upper bound, the next edge reloads the configured lower bound instead of incrementing. With the lower bound at 3 and the upper bound at 13, the counter repeats 3 through 13.

Top module: `dual_en_counter`

## Requirements
- R1: While `clr_n` is low at a rising edge, the count becomes zero at that edge, whatever `ld_n`, `din`, `en_p` and `en_t` are doing. Nothing changes between edges.
- R2: While `clr_n` is high and `ld_n` is low at a rising edge, `q` takes the value of `din` at that edge, whatever the enables are doing. Bit 0 is the least significant bit of both `din` and `q`.
- R3: While `clr_n` and `ld_n` are both high and `en_p` and `en_t` are both high at a rising edge, the count increases by one at that edge. In reduced-range mode, R8 takes over at the upper bound.
- R4: While `clr_n` and `ld_n` are both high and either `en_p` or `en_t` is low at a rising edge, the count holds.
- R5: With reduced-range mode off, counting from the all-ones value wraps to zero. For example, loading 12 and counting gives 13, 14, 15, 0, 1, 2.
- R6: `rco` is combinational and equals `en_t` AND (`q` equals all ones). It stays high for the whole cycle in which both hold, and `en_p` has no effect on it.
- R7: Two 4-bit stages that share `en_p`, with the low stage's `rco` driving the high stage's `en_t`, behave as one 8-bit counter whose carry is high only at count 255 while the chain's `en_t` is high.
- R8: With `WRAP_EN` set, counting while `q` equals `WRAP_HI` loads `WRAP_LO` at that edge. With bounds 3 and 13, a counter started from zero runs 0..13 and then repeats 3..13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every action happens on its rising edge |
| clr_n | input | 1 | Active-low synchronous clear; highest priority |
| ld_n | input | 1 | Active-low synchronous parallel load |
| din | input | WIDTH | Parallel load data, bit 0 least significant |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also qualifies the carry |
| q | output | WIDTH | Current count, bit 0 least significant |
| rco | output | 1 | Terminal-count carry for cascading |

## Verification
The bench checks that clear wins over a simultaneous load with both enables high. A counter with load above clear would show the data word instead of zero. It loads every 4-bit value with the enables low and then with one enable low at a time. This catches a counter that treats the enables as OR, or that lets a load depend on them. It watches the carry with `en_p` low and `en_t` high, where a carry wrongly gated by `en_p` would drop. It then runs a cascaded pair and a reduced-range instance under irregular enable patterns for more than a full 8-bit period. A stage that advanced without its carry, or that missed the reload at 13, would drift away from the 8-bit and 3..13 models.

// File: rtl/dual_en_counter.sv
module dual_en_counter #(
  parameter int WIDTH   = 4,
  parameter bit WRAP_EN = 1'b0,
  parameter int WRAP_LO = 3,
  parameter int WRAP_HI = 13
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic [WIDTH-1:0] din,
  input  logic             en_p,
  input  logic             en_t,
  output logic [WIDTH-1:0] q,
  output logic             rco
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] LO  = WIDTH'(WRAP_LO);
  localparam logic [WIDTH-1:0] HI  = WIDTH'(WRAP_HI);

  logic             run;
  logic [WIDTH-1:0] nxt;

  assign run = en_p & en_t;

  generate
    if (WRAP_EN) begin : g_wrap
      assign nxt = (q == HI) ? LO : q + 1'b1;
    end else begin : g_free
      assign nxt = q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!clr_n)     q <= '0;
    else if (!ld_n) q <= din;
    else if (run)   q <= nxt;
  end

  assign rco = en_t & (q == TOP);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> q == '0);
  assert_load_copies_R2: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !ld_n) |=> q == $past(din));
  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && !(en_p && en_t)) |=> $stable(q));
  assert_carry_at_top_R6: assert property (@(posedge clk) disable iff (!armed)
    rco |-> (q == TOP && en_t));
  assert_step_R3: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && en_p && en_t && !(WRAP_EN && q == HI)) |=> q == $past(q) + 1'b1);
  assert_reload_low_R8: assert property (@(posedge clk) disable iff (!armed)
    (WRAP_EN && clr_n && ld_n && en_p && en_t && q == HI) |=> q == LO);
endmodule

// File: tb/sim_dual_en_counter.sv
module sim_dual_en_counter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic clr_n = 1'b0, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] q0, q1, q2;
  logic rco0, rco1, rco2;

  dual_en_counter #(.WIDTH(4)) u0 (.clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q0), .rco(rco0));
  dual_en_counter #(.WIDTH(4)) u1 (.clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_p(en_p), .en_t(rco0), .q(q1), .rco(rco1));
  dual_en_counter #(.WIDTH(4), .WRAP_EN(1'b1), .WRAP_LO(3), .WRAP_HI(13)) u2 (.clk(clk),
    .clr_n(clr_n), .ld_n(ld_n), .din(din), .en_p(en_p), .en_t(en_t), .q(q2), .rco(rco2));

  int runs = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int m;
    int w;
    tick();
    chk(q0 == 0 && q1 == 0 && q2 == 0, "R1 reset", q0, 0);
    clr_n = 1'b1;

    for (int v = 0; v < 16; v++) begin
      ld_n = 1'b0; din = 4'(v); en_p = 1'b0; en_t = 1'b0;
      tick();
      chk(q0 == 4'(v), "R2 load", q0, v);
      chk(rco0 == 1'b0, "R6 carry needs en_t", rco0, 0);
      ld_n = 1'b1; en_t = 1'b1; #1;
      chk(rco0 == (v == 15), "R6 carry with en_p low", rco0, v == 15);
      tick();
      chk(q0 == 4'(v), "R4 hold en_p low", q0, v);
      en_t = 1'b0; en_p = 1'b1;
      tick();
      chk(q0 == 4'(v), "R4 hold en_t low", q0, v);
    end

    clr_n = 1'b0; ld_n = 1'b0; din = 4'd9; en_p = 1'b1; en_t = 1'b1;
    tick();
    chk(q0 == 0, "R1 clear beats load", q0, 0);

    clr_n = 1'b1; din = 4'd12;
    tick();
    chk(q0 == 12, "R2 load twelve", q0, 12);
    ld_n = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk(q0 == 4'((12 + k) % 16), "R3 R5 count and wrap", q0, (12 + k) % 16);
    end

    clr_n = 1'b0;
    tick();
    clr_n = 1'b1;
    m = 0; w = 0;
    for (int i = 0; i < 600; i++) begin
      en_p = (i % 7) != 3;
      en_t = (i % 11) != 5;
      #1;
      chk(rco1 == (en_t && m == 255), "R7 chain carry", rco1, en_t && m == 255);
      chk(rco2 == 1'b0, "R6 carry absent below top", rco2, 0);
      tick();
      if (en_p && en_t) begin
        m = (m + 1) % 256;
        w = (w == 13) ? 3 : w + 1;
      end
      chk({q1, q0} == 8'(m), "R7 chain count", {q1, q0}, m);
      chk(q2 == 4'(w), "R8 reduced range", q2, w);
    end

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule